// File: doc/BRIEF.md
# Peripheral Power Mode Controller

This block steps the peripheral side of a host bridge between full power and three low-power modes: doze, nap and sleep. Software posts a target mode with a one-cycle write strobe. Doze is taken as soon as the request is seen. Nap and sleep also wait for the processor core to raise its quiesce request. The block drives the quiesce acknowledge back to the core. It also drives enable lines for address decoding, the bus arbiter, memory refresh and the PLL. Those units live elsewhere.

A set of wake events returns the block to full power: a non-maskable interrupt, any interrupt line, a processor bus request (only when enabled) and a bus-master memory access (only in doze). In nap, a memory access from a bus master is serviced in place. The acknowledge stays high, so the core is neither woken nor made to snoop, and the block drops back to plain nap when the access ends. A wake event that coincides with mode entry is held, so the block enters and then leaves. The hard reset is asynchronous and overrides everything.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, with no clock edge needed, the mode reads 00, `core_qack` and `mem_svc` are 0, all four enables are 1, and any posted request is discarded.
- R2: `mode_status` reports the current mode as 00 full, 01 doze, 10 nap, 11 sleep.
- R3: A write of 01 moves the block to doze on the second rising edge after the strobe cycle, whatever `core_qreq` is. `core_qack` stays 0 throughout doze.
- R4: A posted 10 or 11 request waits in full power until `core_qreq` is 1. The mode changes on the edge that sees both. A request is used once, so returning to full power does not re-enter.
- R5: In nap or sleep, `core_qack` rises one cycle after the mode changes. On a wake, `core_qack` falls while the mode still shows nap or sleep, and the mode reads 00 one cycle later.
- R6: Each of `nmi` and every `irq` line is a wake event in any low-power mode. `bus_req` is a wake event only while `cfg_busreq_wake` is 1. In doze, a wake returns the mode to 00 on the next edge.
- R7: `mem_acc_req` wakes the block from doze. In sleep it has no effect on mode or acknowledge.
- R8: In nap with `core_qack` high, `mem_acc_req` sets `mem_svc` on the next edge while mode stays 10 and `core_qack` stays 1. `mem_acc_done` clears `mem_svc` on the next edge, leaving the block in nap.
- R9: Enables are {decode, arbiter, refresh, pll}. They are all 1 in full, doze and nap. In sleep they are decode 0 and arbiter 1, refresh is the inverse of `cfg_sleep_refresh_off`, and pll is the inverse of `cfg_sleep_pll_off`.
- R10: A wake event present in the entry cycle is latched. The block still enters the target mode and then wakes. For nap this takes three cycles: acknowledge up, acknowledge down, then full.
- R11: Writing 00 withdraws a posted nap or sleep request that has not yet been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| cfg_wr | input | 1 | One-cycle write strobe for the target mode |
| cfg_mode | input | 2 | Target mode code written with `cfg_wr` |
| cfg_busreq_wake | input | 1 | Lets `bus_req` act as a wake event |
| cfg_sleep_refresh_off | input | 1 | Turns refresh off in sleep |
| cfg_sleep_pll_off | input | 1 | Turns the PLL off in sleep |
| core_qreq | input | 1 | Quiesce request from the processor core |
| bus_req | input | 1 | Processor bus request |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | IRQ_W | Interrupt lines towards the interrupt controller |
| mem_acc_req | input | 1 | Bus-master memory access pending |
| mem_acc_done | input | 1 | Bus-master memory access completing |
| core_qack | output | 1 | Quiesce acknowledge to the core |
| mode_status | output | 2 | Current mode code |
| mem_svc | output | 1 | Memory access being serviced in nap |
| en_addr_dec | output | 1 | Address decode enable |
| en_arbiter | output | 1 | Bus arbiter enable |
| en_refresh | output | 1 | Memory refresh enable |
| en_pll | output | 1 | PLL enable |

## Verification
The bench builds the block with IRQ_W set to 3 rather than the default 2. Pulsing the highest interrupt line then shows that every line of a widened vector reaches the wake logic. The bench sets the two sleep configuration bits to opposite values in separate sleep visits. This separates the refresh enable from the PLL enable. It also places wake pulses on the exact entry edge and raises a hard reset in the middle of sleep.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
    typedef enum logic [1:0] {
        PM_FULL  = 2'b00,
        PM_DOZE  = 2'b01,
        PM_NAP   = 2'b10,
        PM_SLEEP = 2'b11
    } pm_mode_e;
endpackage

// File: rtl/pm_req_latch.sv
`timescale 1ns/1ps
module pm_req_latch
    import pm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_wr,
    input  pm_mode_e cfg_mode,
    input  pm_mode_e cur_mode,
    input  logic     core_qreq,
    output logic     entry_fire,
    output pm_mode_e entry_mode
);
    typedef struct packed {
        pm_mode_e req;
    } req_st_t;

    req_st_t st_d, st_q;
    logic    wants_quiesce;

    always_comb begin
        st_d          = st_q;
        wants_quiesce = (st_q.req == PM_NAP) || (st_q.req == PM_SLEEP);
        entry_fire    = (cur_mode == PM_FULL) &&
                        ((st_q.req == PM_DOZE) || (wants_quiesce && core_qreq));
        entry_mode    = st_q.req;
        if (entry_fire) begin
            st_d.req = PM_FULL;
        end
        if (cfg_wr) begin
            st_d.req = cfg_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{req: PM_FULL};
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a quiesced mode is only ever taken while the core requests it
    p_fire_needs_qreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_fire && entry_mode != PM_DOZE) |-> core_qreq);
endmodule

// File: rtl/pm_wake_detect.sv
`timescale 1ns/1ps
module pm_wake_detect
    import pm_pkg::*;
#(
    parameter int unsigned IRQ_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pm_mode_e         cur_mode,
    input  logic             entry_fire,
    input  pm_mode_e         entry_mode,
    input  logic             nmi,
    input  logic [IRQ_W-1:0] irq,
    input  logic             bus_req,
    input  logic             busreq_wake_en,
    input  logic             mem_acc_req,
    output logic             wake
);
    typedef struct packed {
        logic pend;
    } wake_st_t;

    wake_st_t st_d, st_q;
    pm_mode_e ev_mode;
    logic     raw;
    logic     any_irq;

    always_comb begin
        st_d    = st_q;
        ev_mode = entry_fire ? entry_mode : cur_mode;
        any_irq = |irq;
        raw     = nmi || any_irq || (bus_req && busreq_wake_en) ||
                  (mem_acc_req && (ev_mode == PM_DOZE));
        if (raw && (entry_fire || cur_mode != PM_FULL)) begin
            st_d.pend = 1'b1;
        end else if (cur_mode == PM_FULL && !entry_fire) begin
            st_d.pend = 1'b0;
        end
        wake = raw || st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a held event only survives in full power for the cycle right after an exit
    p_pend_after_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && cur_mode == PM_FULL) |-> ($past(cur_mode) != PM_FULL));
endmodule

// File: rtl/pm_unit_en.sv
`timescale 1ns/1ps
module pm_unit_en
    import pm_pkg::*;
(
    input  pm_mode_e cur_mode,
    input  logic     sleep_refresh_off,
    input  logic     sleep_pll_off,
    output logic     en_addr_dec,
    output logic     en_arbiter,
    output logic     en_refresh,
    output logic     en_pll
);
    always_comb begin
        en_addr_dec = 1'b1;
        en_arbiter  = 1'b1;
        en_refresh  = 1'b1;
        en_pll      = 1'b1;
        if (cur_mode == PM_SLEEP) begin
            en_addr_dec = 1'b0;
            en_refresh  = !sleep_refresh_off;
            en_pll      = !sleep_pll_off;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned IRQ_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_busreq_wake,
    input  logic             cfg_sleep_refresh_off,
    input  logic             cfg_sleep_pll_off,
    input  logic             core_qreq,
    input  logic             bus_req,
    input  logic             nmi,
    input  logic [IRQ_W-1:0] irq,
    input  logic             mem_acc_req,
    input  logic             mem_acc_done,
    output logic             core_qack,
    output logic [1:0]       mode_status,
    output logic             mem_svc,
    output logic             en_addr_dec,
    output logic             en_arbiter,
    output logic             en_refresh,
    output logic             en_pll
);
    typedef struct packed {
        pm_mode_e mode;
        logic     qack;
        logic     leaving;
        logic     svc;
    } fsm_st_t;

    fsm_st_t  st_d, st_q;
    logic     entry_fire;
    pm_mode_e entry_mode;
    logic     wake;

    pm_req_latch i_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (pm_mode_e'(cfg_mode)),
        .cur_mode  (st_q.mode),
        .core_qreq (core_qreq),
        .entry_fire(entry_fire),
        .entry_mode(entry_mode)
    );

    pm_wake_detect #(.IRQ_W(IRQ_W)) i_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur_mode      (st_q.mode),
        .entry_fire    (entry_fire),
        .entry_mode    (entry_mode),
        .nmi           (nmi),
        .irq           (irq),
        .bus_req       (bus_req),
        .busreq_wake_en(cfg_busreq_wake),
        .mem_acc_req   (mem_acc_req),
        .wake          (wake)
    );

    pm_unit_en i_en (
        .cur_mode         (st_q.mode),
        .sleep_refresh_off(cfg_sleep_refresh_off),
        .sleep_pll_off    (cfg_sleep_pll_off),
        .en_addr_dec      (en_addr_dec),
        .en_arbiter       (en_arbiter),
        .en_refresh       (en_refresh),
        .en_pll           (en_pll)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            PM_FULL: begin
                if (entry_fire) begin
                    st_d.mode = entry_mode;
                    st_d.qack = 1'b0;
                end
            end
            PM_DOZE: begin
                if (wake) begin
                    st_d.mode = PM_FULL;
                end
            end
            PM_NAP, PM_SLEEP: begin
                if (st_q.leaving) begin
                    st_d.mode    = PM_FULL;
                    st_d.leaving = 1'b0;
                end else if (!st_q.qack) begin
                    st_d.qack = 1'b1;
                end else if (wake) begin
                    st_d.qack    = 1'b0;
                    st_d.leaving = 1'b1;
                    st_d.svc     = 1'b0;
                end else if (st_q.mode == PM_NAP) begin
                    if (st_q.svc && mem_acc_done) begin
                        st_d.svc = 1'b0;
                    end else if (!st_q.svc && mem_acc_req) begin
                        st_d.svc = 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PM_FULL, qack: 1'b0, leaving: 1'b0, svc: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign core_qack   = st_q.qack;
    assign mode_status = st_q.mode;
    assign mem_svc     = st_q.svc;

    // R5: acknowledge rises only inside nap or sleep with the mode unchanged
    p_qack_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_qack) |-> ($stable(mode_status) && mode_status[1]));

    // R5: a falling acknowledge is followed by full power
    p_qack_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_qack) |=> (mode_status == 2'b00));

    // R4: leaving full power for nap or sleep needs the core's request
    p_entry_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_status) == 2'b00 && mode_status != 2'b00) |->
            (mode_status == 2'b01 || $past(core_qreq)));

    // R8: servicing keeps the core quiesced in nap
    p_svc_qack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_svc |-> (core_qack && mode_status == 2'b10));

    // R3: doze never acknowledges a quiesce
    p_doze_noqack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b01) |-> !core_qack);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
    localparam int IRQ_W = 3;
    localparam logic [1:0] MF = 2'b00, MD = 2'b01, MN = 2'b10, MS = 2'b11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, cfg_wr, busreq_en, ref_off, pll_off, qreq, bus_req, nmi;
    logic mem_req, mem_done;
    logic [1:0] cfg_mode;
    logic [IRQ_W-1:0] irq;
    logic qack, svc, e_dec, e_arb, e_ref, e_pll;
    logic [1:0] mode;

    pwr_mode_ctrl #(.IRQ_W(IRQ_W)) i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_busreq_wake(busreq_en), .cfg_sleep_refresh_off(ref_off),
        .cfg_sleep_pll_off(pll_off), .core_qreq(qreq), .bus_req(bus_req),
        .nmi(nmi), .irq(irq), .mem_acc_req(mem_req), .mem_acc_done(mem_done),
        .core_qack(qack), .mode_status(mode), .mem_svc(svc),
        .en_addr_dec(e_dec), .en_arbiter(e_arb), .en_refresh(e_ref), .en_pll(e_pll)
    );

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [3:0] en_of(input logic [1:0] m);
        if (m == MS) return {1'b0, 1'b1, ~ref_off, ~pll_off};
        return 4'hf;
    endfunction

    function automatic logic [7:0] pack(input logic [1:0] m, input logic q, input logic s);
        return {m, q, s, en_of(m)};
    endfunction

    task automatic compare(input logic [7:0] exp_v, input string tag);
        logic [7:0] act;
        act = {mode, qack, svc, e_dec, e_arb, e_ref, e_pll};
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: {mode,qack,svc,en} actual=%b expected=%b", tag, act, exp_v);
        end
    endtask

    task automatic tick(input logic [1:0] m, input logic q, input logic s, input string tag);
        exp_t e;
        @(posedge clk);
        e.v   = pack(m, q, s);
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                e = sbq.pop_front();
                compare(e.v, e.tag);
            end
        end
    end

    task automatic wr(input logic [1:0] m);
        cfg_wr = 1'b1; cfg_mode = m;
        tick(MF, 0, 0, "R11 write strobe cycle stays full");
        cfg_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_wr = 0; cfg_mode = 0; busreq_en = 0; ref_off = 0; pll_off = 0;
        qreq = 0; bus_req = 0; nmi = 0; irq = '0; mem_req = 0; mem_done = 0;
        #3;
        compare(pack(MF, 0, 0), "R1 reset state");
        @(negedge clk);
        rst_n = 1;
        tick(MF, 0, 0, "R1 after release");

        // doze by write, core not requesting
        wr(MD);
        tick(MD, 0, 0, "R3 R2 doze entered");
        tick(MD, 0, 0, "R3 doze held");
        nmi = 1;
        tick(MF, 0, 0, "R6 nmi wakes doze");
        nmi = 0;
        tick(MF, 0, 0, "R6 stays full");

        // nap waits for the core
        wr(MN);
        tick(MF, 0, 0, "R4 no qreq no entry");
        tick(MF, 0, 0, "R4 still waiting");
        qreq = 1;
        tick(MN, 0, 0, "R4 R2 nap entered");
        tick(MN, 1, 0, "R5 qack rises");
        irq[IRQ_W-1] = 1'b1;
        tick(MN, 0, 0, "R5 R6 top irq drops qack");
        irq = '0;
        tick(MF, 0, 0, "R5 full after qack");
        tick(MF, 0, 0, "R4 request used once");

        // nap memory service
        wr(MN);
        tick(MN, 0, 0, "R8 nap entry");
        tick(MN, 1, 0, "R8 qack up");
        mem_req = 1;
        tick(MN, 1, 1, "R8 service starts");
        tick(MN, 1, 1, "R8 service held");
        mem_done = 1;
        tick(MN, 1, 0, "R8 back to nap");
        mem_req = 0; mem_done = 0;
        tick(MN, 1, 0, "R8 nap kept");
        bus_req = 1;
        tick(MN, 1, 0, "R6 bus_req ignored when disabled");
        bus_req = 0; nmi = 1;
        tick(MN, 0, 0, "R6 nmi wakes nap");
        nmi = 0;
        tick(MF, 0, 0, "R5 nap exit");

        // sleep, refresh off
        ref_off = 1; pll_off = 0;
        wr(MS);
        tick(MS, 0, 0, "R9 sleep enables refresh off");
        tick(MS, 1, 0, "R5 sleep qack");
        mem_req = 1;
        tick(MS, 1, 0, "R7 mem access ignored in sleep");
        mem_req = 0; bus_req = 1;
        tick(MS, 1, 0, "R6 bus_req blocked");
        busreq_en = 1;
        tick(MS, 0, 0, "R6 bus_req wakes when enabled");
        bus_req = 0; busreq_en = 0;
        tick(MF, 0, 0, "R6 sleep exit");

        // doze woken by memory access
        wr(MD);
        tick(MD, 0, 0, "R7 doze");
        mem_req = 1;
        tick(MF, 0, 0, "R7 mem access wakes doze");
        mem_req = 0;
        tick(MF, 0, 0, "R7 full");

        // wake present in entry cycle
        wr(MN);
        nmi = 1;
        tick(MN, 0, 0, "R10 nap entered despite nmi");
        nmi = 0;
        tick(MN, 1, 0, "R10 qack still rises");
        tick(MN, 0, 0, "R10 latched wake");
        tick(MF, 0, 0, "R10 full");
        wr(MD);
        irq[0] = 1'b1;
        tick(MD, 0, 0, "R10 doze entered despite irq");
        irq = '0;
        tick(MF, 0, 0, "R10 doze latched wake");

        // withdrawing a request
        qreq = 0;
        wr(MN);
        cfg_wr = 1; cfg_mode = MF;
        tick(MF, 0, 0, "R11 cancel write");
        cfg_wr = 0; qreq = 1;
        tick(MF, 0, 0, "R11 cancelled, no entry");
        tick(MF, 0, 0, "R11 still full");

        // sleep, pll off, then hard reset
        ref_off = 0; pll_off = 1;
        wr(MS);
        tick(MS, 0, 0, "R9 sleep enables pll off");
        tick(MS, 1, 0, "R9 sleep qack");
        #2;
        rst_n = 0;
        #1;
        compare(pack(MF, 0, 0), "R1 hard reset mid-sleep");
        @(negedge clk);
        rst_n = 1;
        tick(MF, 0, 0, "R1 request discarded");
        tick(MF, 0, 0, "R1 still full");

        @(negedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule